// File: doc/BRIEF.md
# Time-Multiplexed Phase-Accumulator Oscillator Bank

This block generates periodic waveforms for sixteen oscillator channels (eight voices with two oscillators each) using one shared adder. Each channel owns an 18-bit phase register, an 18-bit phase increment and a 3-bit octave select. An external clock-enable (`slot_tick`) pulses once per channel slot, sixteen times per 50 kHz sample period. Each pulse starts a short pipeline. The pipeline reads the next channel's state, adds the increment to the phase, stores the sum back and presents a wave-table address built from the octave select and the top phase bits. It then returns the 8-bit sample, tagged with its channel number, to a downstream demultiplexer.

The increment for a pitch f is round(2^18 · f / 50000), so the phase covers one waveform cycle in 2^18 steps. Each octave selects its own band-limited table inside the wave memory. A control port writes increments and octave selects and clears a channel's phase at note start.

The sample output is a valid/ready stream. When `smp_valid` is high and `smp_ready` is low, the sample and its tag hold steady and no new slot starts. While the bank is busy, a tick is remembered, but only one: further ticks before the pending slot starts are merged into it. The wave memory must return `tbl_data` for the current `tbl_addr` within the same cycle.

Top module: `osc_bank_tdm`

## Requirements
- R1: After reset, `smp_valid` is 0, `tbl_addr` is 0, every phase, increment and octave select is 0, and the first slot serves channel 0.
- R2: Each slot replaces the channel's phase with (phase + increment) mod 2^18.
- R3: The table address for a slot is {octave select, bits 17..10 of the updated phase}, octave in bits 10..8. The sample delivered is the wave memory's data at that address.
- R4: Slots serve channels in the order 0, 1, …, 15, then wrap to 0. Each sample carries the served channel on `smp_ch`.
- R5: The bank may be idle when a tick is sampled high at a rising edge. In that case `smp_valid` rises right after the second following rising edge.
- R6: While `smp_valid` is 1 and `smp_ready` is 0, `smp_valid`, `smp_data` and `smp_ch` keep their values.
- R7: At most one slot is in flight. One tick that arrives while busy is kept and served as the next slot once the output has been accepted.
- R8: A slot's phase write-back can coincide with a control write (`cfg_we` or `ph_clr`) to the same channel. In that case the control write takes effect and the phase is not updated by that slot. The slot's own sample still uses the sum.
- R9: `ph_clr` sets the phase of channel `cfg_ch` to 0.
- R10: With `cfg_we` high, `cfg_sel` = 0 stores `cfg_data` as the channel's increment. `cfg_sel` = 1 stores bits 2..0 of `cfg_data` as its octave select and ignores the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_tick | input | 1 | Clock-enable requesting the next channel slot |
| cfg_we | input | 1 | Control write strobe |
| cfg_sel | input | 1 | 0: increment, 1: octave select |
| cfg_ch | input | 4 | Channel addressed by a write or clear |
| cfg_data | input | 18 | Write data |
| ph_clr | input | 1 | Clear phase of channel `cfg_ch` |
| tbl_addr | output | 11 | Wave-memory address {octave, phase index} |
| tbl_data | input | 8 | Wave-memory sample for `tbl_addr` |
| smp_valid | output | 1 | Sample stream valid |
| smp_ready | input | 1 | Sample stream ready |
| smp_data | output | 8 | Sample |
| smp_ch | output | 4 | Channel that produced the sample |

## Verification
The embedded properties check the following on every cycle:
- the held output under back-pressure;
- the fixed step from table fetch to valid sample;
- that no slot starts while one is in flight;
- that a clear zeroes the phase;
- that a colliding control write blocks the phase write-back.

The arithmetic can only be shown by the bench's scenarios, which compare samples against a reference model of phases and table contents:
- the modulo-2^18 wrap;
- the address layout with the octave on top;
- the channel rotation;
- the merging of a tick that arrives while busy;
- the net effect of a collision or clear on later samples of that channel.

// File: rtl/osc_tdm_pkg.sv
package osc_tdm_pkg;
  typedef enum logic {
    SEL_INC = 1'b0,
    SEL_OCT = 1'b1
  } cfg_sel_e;

  // Slot context carried from the read stage to the add stage.
  typedef struct packed {
    logic [3:0]  ch;
    logic [2:0]  oct;
    logic [17:0] inc;
    logic [17:0] ph;
  } slot_ctx_t;
endpackage

// File: rtl/osc_slot_seq.sv
module osc_slot_seq #(
  parameter int NCH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   busy,
  output logic                   start,
  output logic [$clog2(NCH)-1:0] slot
);
  localparam int CH_W = $clog2(NCH);

  logic            pend_q;
  logic [CH_W-1:0] slot_q;

  assign start = (tick | pend_q) & ~busy;
  assign slot  = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      slot_q <= '0;
    end else begin
      pend_q <= (pend_q | tick) & ~start;
      if (start) begin
        if (slot_q == CH_W'(NCH - 1)) slot_q <= '0;
        else                          slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/osc_chan_store.sv
module osc_chan_store
  import osc_tdm_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int PH_W  = 18,
  parameter int OCT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_sel,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [PH_W-1:0]        cfg_data,
  input  logic                   ph_clr,
  input  logic [$clog2(NCH)-1:0] rd_ch,
  output logic [PH_W-1:0]        rd_inc,
  output logic [OCT_W-1:0]       rd_oct,
  output logic [PH_W-1:0]        rd_ph,
  input  logic                   wb_en,
  input  logic [$clog2(NCH)-1:0] wb_ch,
  input  logic [PH_W-1:0]        wb_ph
);
  localparam int CH_W = $clog2(NCH);

  logic [PH_W-1:0]  inc_q [NCH];
  logic [OCT_W-1:0] oct_q [NCH];
  logic [PH_W-1:0]  ph_q  [NCH];

  cfg_sel_e sel;
  logic     ctl_hit;
  logic [PH_W-1:0] wb_cur;

  assign sel     = cfg_sel_e'(cfg_sel);
  assign ctl_hit = (cfg_we | ph_clr) && (cfg_ch == wb_ch);
  assign wb_cur  = ph_q[wb_ch];

  assign rd_inc = inc_q[rd_ch];
  assign rd_oct = oct_q[rd_ch];
  assign rd_ph  = ph_q[rd_ch];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        inc_q[c] <= '0;
        oct_q[c] <= '0;
        ph_q[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (cfg_we && cfg_ch == CH_W'(c)) begin
          if (sel == SEL_INC) inc_q[c] <= cfg_data;
          else                oct_q[c] <= cfg_data[OCT_W-1:0];
        end
        if (ph_clr && cfg_ch == CH_W'(c))
          ph_q[c] <= '0;
        else if (wb_en && wb_ch == CH_W'(c) && !ctl_hit)
          ph_q[c] <= wb_ph;
      end
    end
  end

  AST_WB_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && cfg_we && !ph_clr && cfg_ch == wb_ch) |=> ph_q[$past(wb_ch)] == $past(wb_cur)); // R8

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ph_clr |=> ph_q[$past(cfg_ch)] == '0); // R9
endmodule

// File: rtl/osc_phase_pipe.sv
module osc_phase_pipe
  import osc_tdm_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int PH_W  = 18,
  parameter int OCT_W = 3,
  parameter int IDX_W = 8,
  parameter int SMP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [$clog2(NCH)-1:0]   start_ch,
  input  logic [PH_W-1:0]          rd_inc,
  input  logic [OCT_W-1:0]         rd_oct,
  input  logic [PH_W-1:0]          rd_ph,
  output logic                     wb_en,
  output logic [$clog2(NCH)-1:0]   wb_ch,
  output logic [PH_W-1:0]          wb_ph,
  output logic [OCT_W+IDX_W-1:0]   tbl_addr,
  input  logic [SMP_W-1:0]         tbl_data,
  output logic                     smp_valid,
  input  logic                     smp_ready,
  output logic [SMP_W-1:0]         smp_data,
  output logic [$clog2(NCH)-1:0]   smp_ch,
  output logic                     busy
);
  localparam int CH_W   = $clog2(NCH);
  localparam int ADDR_W = OCT_W + IDX_W;

  // Stage A: channel state captured from the store.
  logic             a_vld;
  logic [CH_W-1:0]  a_ch;
  logic [OCT_W-1:0] a_oct;
  logic [PH_W-1:0]  a_inc, a_ph;
  // Stage B: table address presented to wave memory.
  logic             b_vld;
  logic [CH_W-1:0]  b_ch;
  logic [ADDR_W-1:0] addr_q;
  // Output register.
  logic             o_vld;
  logic [SMP_W-1:0] o_data;
  logic [CH_W-1:0]  o_ch;

  logic [PH_W-1:0]  sum;

  assign sum   = a_ph + a_inc;
  assign wb_en = a_vld;
  assign wb_ch = a_ch;
  assign wb_ph = sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld <= 1'b0;
      a_ch  <= '0;
      a_oct <= '0;
      a_inc <= '0;
      a_ph  <= '0;
    end else begin
      a_vld <= start;
      if (start) begin
        a_ch  <= start_ch;
        a_oct <= rd_oct;
        a_inc <= rd_inc;
        a_ph  <= rd_ph;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_vld  <= 1'b0;
      b_ch   <= '0;
      addr_q <= '0;
    end else begin
      b_vld <= a_vld;
      if (a_vld) begin
        b_ch   <= a_ch;
        addr_q <= {a_oct, sum[PH_W-1 -: IDX_W]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld  <= 1'b0;
      o_data <= '0;
      o_ch   <= '0;
    end else if (b_vld) begin
      o_vld  <= 1'b1;
      o_data <= tbl_data;
      o_ch   <= b_ch;
    end else if (smp_ready) begin
      o_vld  <= 1'b0;
    end
  end

  assign tbl_addr  = addr_q;
  assign smp_valid = o_vld;
  assign smp_data  = o_data;
  assign smp_ch    = o_ch;
  assign busy      = a_vld | b_vld | o_vld;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data) && $stable(smp_ch))); // R6

  AST_FETCH_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    b_vld |=> smp_valid); // R5

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !(a_vld || b_vld || smp_valid)); // R7

  AST_SINGLE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_vld, b_vld, o_vld})); // R7
endmodule

// File: rtl/osc_bank_tdm.sv
module osc_bank_tdm
  import osc_tdm_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int PH_W  = 18,
  parameter int OCT_W = 3,
  parameter int IDX_W = 8,
  parameter int SMP_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       slot_tick,
  input  logic                       cfg_we,
  input  logic                       cfg_sel,
  input  logic [$clog2(NCH)-1:0]     cfg_ch,
  input  logic [PH_W-1:0]            cfg_data,
  input  logic                       ph_clr,
  output logic [OCT_W+IDX_W-1:0]     tbl_addr,
  input  logic [SMP_W-1:0]           tbl_data,
  output logic                       smp_valid,
  input  logic                       smp_ready,
  output logic [SMP_W-1:0]           smp_data,
  output logic [$clog2(NCH)-1:0]     smp_ch
);
  localparam int CH_W = $clog2(NCH);

  logic             start, busy, wb_en;
  logic [CH_W-1:0]  slot, wb_ch;
  logic [PH_W-1:0]  rd_inc, rd_ph, wb_ph;
  logic [OCT_W-1:0] rd_oct;

  osc_slot_seq #(.NCH(NCH)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (slot_tick),
    .busy  (busy),
    .start (start),
    .slot  (slot)
  );

  osc_chan_store #(.NCH(NCH), .PH_W(PH_W), .OCT_W(OCT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_ch   (cfg_ch),
    .cfg_data (cfg_data),
    .ph_clr   (ph_clr),
    .rd_ch    (slot),
    .rd_inc   (rd_inc),
    .rd_oct   (rd_oct),
    .rd_ph    (rd_ph),
    .wb_en    (wb_en),
    .wb_ch    (wb_ch),
    .wb_ph    (wb_ph)
  );

  osc_phase_pipe #(
    .NCH(NCH), .PH_W(PH_W), .OCT_W(OCT_W), .IDX_W(IDX_W), .SMP_W(SMP_W)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_ch  (slot),
    .rd_inc    (rd_inc),
    .rd_oct    (rd_oct),
    .rd_ph     (rd_ph),
    .wb_en     (wb_en),
    .wb_ch     (wb_ch),
    .wb_ph     (wb_ph),
    .tbl_addr  (tbl_addr),
    .tbl_data  (tbl_data),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .smp_ch    (smp_ch),
    .busy      (busy)
  );
endmodule

// File: tb/tb_osc_bank_tdm.sv
module tb_osc_bank_tdm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_tick = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [3:0]  cfg_ch = '0;
  logic [17:0] cfg_data = '0;
  logic        ph_clr = 1'b0;
  logic [10:0] tbl_addr;
  logic [7:0]  tbl_data;
  logic        smp_valid;
  logic        smp_ready = 1'b0;
  logic [7:0]  smp_data;
  logic [3:0]  smp_ch;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [17:0] inc_m [16];
  logic [2:0]  oct_m [16];
  logic [17:0] ph_m  [16];
  int          exp_slot = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] rom(input logic [10:0] a);
    logic [10:0] t;
    t = (a * 11'd37) ^ (a >> 3) ^ 11'h0A5;
    return t[7:0];
  endfunction

  assign tbl_data = rom(tbl_addr);

  osc_bank_tdm dut (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_ch(cfg_ch), .cfg_data(cfg_data),
    .ph_clr(ph_clr), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data), .smp_ch(smp_ch)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input int ch, input logic [17:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_ch = 4'(ch); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!sel) inc_m[ch] = d;
    else      oct_m[ch] = d[2:0];  // R10: only bits 2..0 kept
  endtask

  task automatic clear_phase(input int ch);
    @(negedge clk);
    ph_clr = 1'b1; cfg_ch = 4'(ch);
    @(negedge clk);
    ph_clr = 1'b0;
    ph_m[ch] = '0;  // R9
  endtask

  task automatic collect(input int ch, input logic [7:0] es, input bit bp, input string req);
    int guard = 0;
    while (!smp_valid && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chk(smp_valid, "R7 sample produced", longint'(smp_valid), 1);
    if (bp) begin
      int hold = 1 + int'($urandom % 3);
      logic [7:0] d0 = smp_data;
      logic [3:0] c0 = smp_ch;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(smp_valid && smp_data == d0 && smp_ch == c0, "R6 hold under back-pressure",
            longint'({smp_valid, smp_ch, smp_data}), longint'({1'b1, c0, d0}));
      end
    end
    chk(smp_ch == 4'(ch), {req, " R4 channel tag"}, longint'(smp_ch), longint'(ch));
    chk(smp_data == es, {req, " R2/R3 sample"}, longint'(smp_data), longint'(es));
    smp_ready = 1'b1;
    @(negedge clk);
    smp_ready = 1'b0;
  endtask

  task automatic run_slot(input bit bp, input bit chk_lat, input bit collide,
                          input logic [17:0] new_inc, input string req);
    int ch;
    logic [17:0] sum;
    logic [7:0]  es;
    ch  = exp_slot;
    sum = ph_m[ch] + inc_m[ch];
    es  = rom({oct_m[ch], sum[17:10]});
    @(negedge clk);
    slot_tick = 1'b1;
    @(negedge clk);
    slot_tick = 1'b0;
    if (collide) begin
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_ch = 4'(ch); cfg_data = new_inc;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    if (chk_lat) chk(!smp_valid, "R5 not valid one cycle early", longint'(smp_valid), 0);
    @(negedge clk);
    if (chk_lat) chk(smp_valid, "R5 valid after second edge", longint'(smp_valid), 1);
    collect(ch, es, bp, req);
    if (collide) inc_m[ch] = new_inc;  // R8: phase kept, increment replaced
    else         ph_m[ch]  = sum;
    exp_slot = (exp_slot + 1) % 16;
  endtask

  task automatic run_pair();
    int c0, c1;
    logic [17:0] s0, s1;
    logic [7:0]  e0, e1;
    c0 = exp_slot; c1 = (exp_slot + 1) % 16;
    s0 = ph_m[c0] + inc_m[c0]; e0 = rom({oct_m[c0], s0[17:10]});
    s1 = ph_m[c1] + inc_m[c1]; e1 = rom({oct_m[c1], s1[17:10]});
    @(negedge clk);
    slot_tick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    slot_tick = 1'b0;
    collect(c0, e0, 1'b0, "R7 first of pair");
    collect(c1, e1, 1'b0, "R7 pending tick served");
    ph_m[c0] = s0; ph_m[c1] = s1;
    exp_slot = (exp_slot + 2) % 16;
    repeat (6) @(negedge clk);
    chk(!smp_valid, "R7 no extra slot from merged ticks", longint'(smp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      inc_m[i] = '0; oct_m[i] = '0; ph_m[i] = '0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!smp_valid, "R1 valid low after reset", longint'(smp_valid), 0);
    chk(tbl_addr == '0, "R1 table address zero after reset", longint'(tbl_addr), 0);
    run_slot(1'b0, 1'b1, 1'b0, '0, "R1 first slot is channel 0");

    for (int c = 0; c < 16; c++) begin
      cfg_write(1'b0, c, 18'($urandom));
      cfg_write(1'b1, c, 18'($urandom));
    end
    cfg_write(1'b0, 3, 18'h3FFFF);          // R2 wrap: phase steps backwards by one
    cfg_write(1'b0, 7, 18'h20000);          // R2 wrap: half cycle per slot
    cfg_write(1'b1, 5, 18'h3FFFD);          // R10 upper bits ignored, octave 5
    cfg_write(1'b1, 9, 18'h00007);          // R3 octave 7 in top address bits
    for (int k = 0; k < 40; k++) run_slot(1'b0, 1'b1, 1'b0, '0, "R2 sweep");

    run_pair();                              // R7
    run_slot(1'b0, 1'b0, 1'b1, 18'h01234, "R8 collision");
    for (int k = 0; k < 16; k++) run_slot(1'b0, 1'b0, 1'b0, '0, "R8 after collision");
    clear_phase(exp_slot);                   // R9
    run_slot(1'b0, 1'b1, 1'b0, '0, "R9 cleared channel");

    for (int it = 0; it < 220; it++) begin
      int r = int'($urandom % 8);
      case (r)
        0: cfg_write(1'($urandom), int'($urandom % 16), 18'($urandom));
        1: clear_phase(int'($urandom % 16));
        2: run_slot(1'($urandom), 1'b0, 1'b1, 18'($urandom), "R8 random collision");
        3: run_pair();
        default: run_slot(1'($urandom), 1'b0, 1'b0, '0, "R6 random stream");
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule